// File: doc/BRIEF.md
# Backplane Slave Handshake Sequencer

This block paces one data cycle of an asynchronous parallel backplane on a 16-bit slave card. The master drives an address strobe, two data strobes and a direction line with no clock of its own. The block brings those lines into the local clock domain, waits for the card-select flag from the address decoder, and then steps through a fixed sequence. It turns the data transceivers on and points them the right way. It gives the local register set a single read or write strobe. Only after that does it pull the acknowledge low.

The acknowledge stays low until the master has released both data strobes. The sequencer then turns the transceivers off and goes back to waiting. If the address strobe is withdrawn part way through a cycle, the cycle is dropped and every output returns to its inactive level. A new cycle can start only after the data strobes have been seen released.

Top module: `bus_ack_fsm`

## Requirements
- R1: While reset is low and just after it, `dtack_n_o` and `buf_en_n_o` are 1, and `buf_dir_o`, `rd_stb_o` and `wr_stb_o` are 0.
- R2: A cycle starts only if `card_sel_i` is 1, `as_n_i` is 0 and at least one bit of `ds_n_i` is 0. If any of these is missing, no output leaves its idle level.
- R3: With default parameters, `buf_en_n_o` goes low at the 4th rising edge after the strobes go active. While it is low, `buf_dir_o` is 1 for a read (`write_n_i` = 1) and 0 for a write (`write_n_i` = 0), and it holds that value.
- R4: On a read, `rd_stb_o` is high for exactly one clock, `SETTLE_CYC` clocks after the buffer enable (the 5th edge with defaults). `dtack_n_o` goes low on the next edge (the 6th).
- R5: On a write, `wr_stb_o` is high for exactly one clock with the same timing as R4. `dtack_n_o` goes low on the edge after it.
- R6: `dtack_n_o` stays low while either data strobe is low. It rises together with `buf_en_n_o` at the 3rd rising edge after both data strobes are high.
- R7: A cycle gives exactly one register strobe. A new cycle needs the data strobes to be seen high first, even if the address strobe was withdrawn and asserted again.
- R8: If `as_n_i` goes high during a cycle, all outputs return to idle by the 3rd edge after it. If the abort comes before the access step, no register strobe is issued.
- R9: `rd_stb_o` and `wr_stb_o` are never high together, and either one is high only while `buf_en_n_o` is low.
- R10: `dtack_n_o` is low only while `buf_en_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_sel_i | input | 1 | Card-select flag from the address decoder, 1 = this card is addressed |
| as_n_i | input | 1 | Address strobe from the backplane, active low, asynchronous |
| ds_n_i | input | 2 | Data strobes from the backplane, active low, asynchronous |
| write_n_i | input | 1 | Direction line, 0 = write, 1 = read, asynchronous |
| buf_en_n_o | output | 1 | Data transceiver enable, active low |
| buf_dir_o | output | 1 | Transceiver direction, 1 = card drives the backplane |
| rd_stb_o | output | 1 | One-clock read strobe to the register set |
| wr_stb_o | output | 1 | One-clock write capture strobe to the register set |
| dtack_n_o | output | 1 | Data acknowledge to the master, active low |

## Verification
Reads and writes are each run with the lower strobe alone, the upper strobe alone and both strobes. This separates the direction control from the pulse selection and shows that one strobe is enough to start a cycle. Releasing one strobe of a pair, and waiting with the address strobe still low after release, shows that the acknowledge waits for both strobes and that no second pulse follows. An early abort, a late abort followed by a reasserted address strobe, a deselected card and an address strobe with no data strobe each test a different guard on the start and on the abort paths.

// File: rtl/bus_ack_pkg.sv
package bus_ack_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_DECODE  = 3'd1,
      ST_ENABLE  = 3'd2,
      ST_ACCESS  = 3'd3,
      ST_ACK     = 3'd4,
      ST_RELEASE = 3'd5
   } xfer_state_e;

   // Backplane control lines grouped for synchronization (all active low)
   typedef struct packed {
      logic       as_n;
      logic [1:0] ds_n;
      logic       write_n;
   } bus_ctl_t;

   localparam int unsigned CTL_W = $bits(bus_ctl_t);

endpackage

// File: rtl/bus_ack_sync.sv
module bus_ack_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [STAGES-1:0][W-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bus_ack_ctrl.sv
module bus_ack_ctrl
   import bus_ack_pkg::*;
#(
   parameter int unsigned SETTLE_CYC = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        card_sel_i,
   input  bus_ctl_t    ctl_s_i,
   output xfer_state_e state_o,
   output logic        read_o
);

   localparam int unsigned CNT_W = $clog2(SETTLE_CYC) + 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

   xfer_state_e st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic read_q;
   logic armed_q;
   logic ds_any_low, ds_all_high, start_ok;

   assign ds_any_low  = (ctl_s_i.ds_n != 2'b11);
   assign ds_all_high = &ctl_s_i.ds_n;
   assign start_ok    = card_sel_i && !ctl_s_i.as_n && ds_any_low && armed_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:    if (start_ok) st_d = ST_DECODE;
         ST_DECODE:  st_d = ctl_s_i.as_n ? ST_IDLE : ST_ENABLE;
         ST_ENABLE: begin
            if (ctl_s_i.as_n)           st_d = ST_IDLE;
            else if (cnt_q == CNT_LAST) st_d = ST_ACCESS;
         end
         ST_ACCESS:  st_d = ctl_s_i.as_n ? ST_IDLE : ST_ACK;
         ST_ACK: begin
            if (ctl_s_i.as_n)     st_d = ST_IDLE;
            else if (ds_all_high) st_d = ST_RELEASE;
         end
         ST_RELEASE: st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   // Settle counter runs only while the transceivers are being enabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (st_q == ST_ENABLE) cnt_q <= cnt_q + 1'b1;
      else                        cnt_q <= '0;
   end

   // Direction is latched once per cycle from the synchronized write line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 read_q <= 1'b0;
      else if (st_q == ST_DECODE) read_q <= ctl_s_i.write_n;
   end

   // Re-arm only after the data strobes have been seen released
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 armed_q <= 1'b1;
      else if (ds_all_high)       armed_q <= 1'b1;
      else if (st_q == ST_DECODE) armed_q <= 1'b0;
   end

   assign state_o = st_q;
   assign read_o  = read_q;

endmodule

// File: rtl/bus_ack_outdec.sv
module bus_ack_outdec
   import bus_ack_pkg::*;
(
   input  xfer_state_e state_i,
   input  logic        read_i,
   output logic        buf_en_n_o,
   output logic        buf_dir_o,
   output logic        rd_stb_o,
   output logic        wr_stb_o,
   output logic        dtack_n_o
);

   logic buf_on;

   always_comb begin
      buf_on = (state_i == ST_ENABLE) || (state_i == ST_ACCESS) || (state_i == ST_ACK);
      buf_en_n_o = !buf_on;
      buf_dir_o  = buf_on && read_i;
      rd_stb_o   = (state_i == ST_ACCESS) && read_i;
      wr_stb_o   = (state_i == ST_ACCESS) && !read_i;
      dtack_n_o  = (state_i != ST_ACK);
   end

endmodule

// File: rtl/bus_ack_fsm.sv
module bus_ack_fsm
   import bus_ack_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SETTLE_CYC  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       card_sel_i,
   input  logic       as_n_i,
   input  logic [1:0] ds_n_i,
   input  logic       write_n_i,
   output logic       buf_en_n_o,
   output logic       buf_dir_o,
   output logic       rd_stb_o,
   output logic       wr_stb_o,
   output logic       dtack_n_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bus_ack_fsm: SYNC_STAGES must be at least 2");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("bus_ack_fsm: SETTLE_CYC must be at least 1");
   end

   bus_ctl_t    ctl_raw, ctl_s;
   logic [CTL_W-1:0] ctl_s_vec;
   xfer_state_e state;
   logic        read_dir;

   assign ctl_raw = '{as_n: as_n_i, ds_n: ds_n_i, write_n: write_n_i};

   bus_ack_sync #(
      .W       (CTL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({CTL_W{1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ctl_raw),
      .q_o   (ctl_s_vec)
   );

   assign ctl_s = bus_ctl_t'(ctl_s_vec);

   bus_ack_ctrl #(
      .SETTLE_CYC (SETTLE_CYC)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .card_sel_i (card_sel_i),
      .ctl_s_i    (ctl_s),
      .state_o    (state),
      .read_o     (read_dir)
   );

   bus_ack_outdec u_out (
      .state_i    (state),
      .read_i     (read_dir),
      .buf_en_n_o (buf_en_n_o),
      .buf_dir_o  (buf_dir_o),
      .rd_stb_o   (rd_stb_o),
      .wr_stb_o   (wr_stb_o),
      .dtack_n_o  (dtack_n_o)
   );

endmodule

// File: rtl/bus_ack_chk.sv
module bus_ack_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       as_n_i,
   input logic [1:0] ds_n_i,
   input logic       buf_en_n_o,
   input logic       buf_dir_o,
   input logic       rd_stb_o,
   input logic       wr_stb_o,
   input logic       dtack_n_o
);

   AST_ACK_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      !dtack_n_o |-> !buf_en_n_o); // R10

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb_o && wr_stb_o)); // R9

   AST_PULSE_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_o || wr_stb_o) |-> !buf_en_n_o); // R9

   AST_RD_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb_o |=> !rd_stb_o); // R4

   AST_WR_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o); // R5

   AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dtack_n_o) |-> $past(rd_stb_o || wr_stb_o)); // R4

   AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dtack_n_o) |-> ($past(&ds_n_i, 2) || $past(as_n_i, 2))); // R6

   AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_en_n_o && $past(!buf_en_n_o)) |-> $stable(buf_dir_o)); // R3

endmodule

bind bus_ack_fsm bus_ack_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .as_n_i     (as_n_i),
   .ds_n_i     (ds_n_i),
   .buf_en_n_o (buf_en_n_o),
   .buf_dir_o  (buf_dir_o),
   .rd_stb_o   (rd_stb_o),
   .wr_stb_o   (wr_stb_o),
   .dtack_n_o  (dtack_n_o)
);

// File: tb/sim_bus_ack_fsm.sv
module sim_bus_ack_fsm;

   localparam time CLK_PER  = 10ns;
   localparam int  SYNC     = 2;
   localparam int  SETTLE   = 1;
   localparam int  EN_AT    = SYNC + 2;
   localparam int  PULSE_AT = EN_AT + SETTLE;
   localparam int  ACK_AT   = PULSE_AT + 1;
   localparam int  REL_LAT  = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic card_sel = 1'b1;
   logic as_n = 1'b1;
   logic [1:0] ds_n = 2'b11;
   logic write_n = 1'b1;
   logic buf_en_n, buf_dir, rd_stb, wr_stb, dtack_n;

   int n_chk = 0;
   int n_fail = 0;
   int cyc, en_at, pulse_at, ack_at, rd_cnt, wr_cnt, dir_seen;
   bit done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   bus_ack_fsm #(.SYNC_STAGES(SYNC), .SETTLE_CYC(SETTLE)) u0 (
      .clk(clk), .rst_n(rst_n), .card_sel_i(card_sel), .as_n_i(as_n),
      .ds_n_i(ds_n), .write_n_i(write_n), .buf_en_n_o(buf_en_n),
      .buf_dir_o(buf_dir), .rd_stb_o(rd_stb), .wr_stb_o(wr_stb),
      .dtack_n_o(dtack_n)
   );

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_mon();
      cyc = 0; en_at = -1; pulse_at = -1; ack_at = -1;
      rd_cnt = 0; wr_cnt = 0; dir_seen = -1;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (!buf_en_n && en_at < 0) begin
         en_at = cyc;
         dir_seen = int'(buf_dir);
      end
      if (rd_stb) begin rd_cnt++; if (pulse_at < 0) pulse_at = cyc; end
      if (wr_stb) begin wr_cnt++; if (pulse_at < 0) pulse_at = cyc; end
      if (!dtack_n && ack_at < 0) ack_at = cyc;
   endtask

   task automatic idle_outputs(string req, string tag);
      check(req, {tag, " dtack_n"}, int'(dtack_n), 1);
      check(req, {tag, " buf_en_n"}, int'(buf_en_n), 1);
      check(req, {tag, " rd+wr"}, int'(rd_stb) + int'(wr_stb), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      clear_mon();
      repeat (3) step();
      idle_outputs("R1", "in reset");
      check("R1", "dir in reset", int'(buf_dir), 0);
      rst_n = 1'b1;
      step();
      idle_outputs("R1", "after reset");
      check("R1", "dir after reset", int'(buf_dir), 0);
   endtask

   // Full transfer: strobes asserted, acknowledged, then released
   task automatic t_xfer(bit is_wr, logic [1:0] ds_pat, bit split_release);
      string rq;
      rq = is_wr ? "R5" : "R4";
      clear_mon();
      write_n = !is_wr; as_n = 1'b0; ds_n = ds_pat;
      repeat (ACK_AT + 2) step();
      check("R3", "buffer enable edge", en_at, EN_AT);
      check("R3", "direction", dir_seen, is_wr ? 0 : 1);
      check(rq, "strobe edge", pulse_at, PULSE_AT);
      check(rq, "read strobes", rd_cnt, is_wr ? 0 : 1);
      check(rq, "write strobes", wr_cnt, is_wr ? 1 : 0);
      check(rq, "ack edge", ack_at, ACK_AT);
      if (split_release) begin
         ds_n = 2'b01;               // only the lower strobe released
         repeat (6) step();
         check("R6", "ack held with one strobe low", int'(dtack_n), 0);
      end
      ds_n = 2'b11;
      cyc = 0;
      while (!dtack_n && cyc < 10) step();
      check("R6", "ack release latency", cyc, REL_LAT);
      check("R6", "buffer off with ack", int'(buf_en_n), 1);
      repeat (5) step();              // address strobe still low
      check("R7", "strobes per cycle", rd_cnt + wr_cnt, 1);
      check("R7", "no restart ack", int'(dtack_n), 1);
      as_n = 1'b1;
      repeat (3) step();
   endtask

   task automatic t_not_selected();
      clear_mon();
      card_sel = 1'b0; as_n = 1'b0; ds_n = 2'b00; write_n = 1'b1;
      repeat (10) step();
      check("R2", "deselected buffer", en_at, -1);
      check("R2", "deselected strobes", rd_cnt + wr_cnt, 0);
      check("R2", "deselected ack", ack_at, -1);
      as_n = 1'b1; ds_n = 2'b11; card_sel = 1'b1;
      repeat (4) step();
   endtask

   task automatic t_no_data_strobe();
      clear_mon();
      as_n = 1'b0; ds_n = 2'b11; write_n = 1'b0;
      repeat (10) step();
      check("R2", "no data strobe buffer", en_at, -1);
      check("R2", "no data strobe ack", ack_at, -1);
      as_n = 1'b1;
      repeat (4) step();
   endtask

   task automatic t_early_abort();
      clear_mon();
      write_n = 1'b0; as_n = 1'b0; ds_n = 2'b00;
      step();
      as_n = 1'b1;
      repeat (8) step();
      check("R8", "early abort buffer", en_at, -1);
      check("R8", "early abort strobes", rd_cnt + wr_cnt, 0);
      check("R8", "early abort ack", ack_at, -1);
      ds_n = 2'b11;
      repeat (4) step();
   endtask

   task automatic t_late_abort();
      clear_mon();
      write_n = 1'b1; as_n = 1'b0; ds_n = 2'b00;
      repeat (ACK_AT + 1) step();
      check("R8", "late abort reached ack", int'(dtack_n), 0);
      as_n = 1'b1;
      repeat (REL_LAT) step();
      idle_outputs("R8", "after late abort");
      as_n = 1'b0;                    // data strobes never released
      repeat (10) step();
      check("R7", "re-asserted address, strobes", rd_cnt + wr_cnt, 1);
      check("R7", "re-asserted address, ack", int'(dtack_n), 1);
      as_n = 1'b1; ds_n = 2'b11;
      repeat (4) step();
   endtask

   initial begin
      t_reset();
      t_xfer(1'b0, 2'b10, 1'b0);      // read, lower strobe only
      t_xfer(1'b1, 2'b01, 1'b0);      // write, upper strobe only
      t_xfer(1'b0, 2'b00, 1'b1);      // read, both, staggered release
      t_xfer(1'b1, 2'b00, 1'b1);      // write, both, staggered release
      t_not_selected();
      t_no_data_strobe();
      t_early_abort();
      t_late_abort();
      t_xfer(1'b1, 2'b00, 1'b0);      // clean cycle after aborts
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule